// File: doc/BRIEF.md
# Instruction Control Decoder

This block is the control decoder of a single-cycle processor core. It reads the 6-bit opcode and the 6-bit function field of the current instruction and drives every datapath control line in the same cycle: the destination-register choice, the second ALU operand choice, the write-back source, the register-file write enable, the data-memory read and write enables, the branch and jump flags, and a 3-bit ALU operation code.

The ALU operation is picked in two stages. The first stage turns the opcode into a 2-bit operation class. The second stage uses that class, and the function field when the class says so, to pick the ALU operation. The block has no state and no clock. Any opcode outside the supported set drives all enables low, so the instruction does nothing. An R-type instruction with an unsupported function code also drives all enables low.

Top module: `ctrl_decoder`

## Requirements
- R1: Opcode 35 (load) drives dst_from_rd=0, b_from_imm=1, wb_from_mem=1, rf_we=1, dm_re=1, dm_we=0, is_branch=0, is_jump=0, alu_class=00 and alu_fn=010.
- R2: Opcode 0 (R-type) with a supported function code drives dst_from_rd=1, b_from_imm=0, wb_from_mem=0, rf_we=1, dm_re=0, dm_we=0, is_branch=0, is_jump=0 and alu_class=10.
- R3: Opcode 43 (store) drives b_from_imm=1 and dm_we=1. It drives rf_we=0, dm_re=0, wb_from_mem=0, dst_from_rd=0, is_branch=0, is_jump=0, alu_class=00 and alu_fn=010.
- R4: Opcode 4 (branch if equal) drives is_branch=1, alu_class=01 and alu_fn=110. All enables are 0, and so are b_from_imm, is_jump, wb_from_mem and dst_from_rd.
- R5: Opcode 2 (jump) drives is_jump=1 and alu_class=11 with alu_fn=000. All enables are 0, and so are is_branch and the three selects.
- R6: With alu_class=10, the function field selects alu_fn as follows: 32 gives 010 (add), 34 gives 110 (subtract), 36 gives 000 (and), 37 gives 001 (or) and 42 gives 111 (set if less than).
- R7: Opcode 0 with any other function code drives rf_we=0, dm_re=0, dm_we=0 and alu_fn=000.
- R8: An opcode other than 0, 2, 4, 35 or 43 drives rf_we, dm_re, dm_we, is_branch, is_jump, b_from_imm, wb_from_mem and dst_from_rd all to 0, with alu_class=00 and alu_fn=010.
- R9: alu_class=00 forces alu_fn=010 and alu_class=01 forces alu_fn=110, whatever the function field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction opcode field |
| funct | input | 6 | Instruction function field |
| dst_from_rd | output | 1 | 1: destination register comes from the rd field; 0: from the rt field |
| b_from_imm | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_from_mem | output | 1 | 1: register write-back data comes from data memory |
| rf_we | output | 1 | Register file write enable |
| dm_re | output | 1 | Data memory read enable |
| dm_we | output | 1 | Data memory write enable |
| is_branch | output | 1 | Branch-if-equal instruction |
| is_jump | output | 1 | Unconditional jump instruction |
| alu_class | output | 2 | First-stage operation class |
| alu_fn | output | 3 | Selected ALU operation |

## Verification
The hardest case to reach is an instruction the decoder must reject while its function field still holds a valid arithmetic code. Two examples are an unsupported opcode paired with function 32, and a load or store paired with function 42. A wrong decoder could leak that function code into alu_fn or raise a write enable. The bench sweeps all 64 opcodes with a valid function code and all 64 function codes under opcode 0. It also pairs loads, stores and branches with arithmetic function codes, so that any leak from the second stage shows up at the ports.

// File: rtl/ctrl_decoder.sv
module ctrl_decoder #(
  parameter int OPW = 6,
  parameter int FNW = 6,
  parameter int AW  = 3,
  parameter logic [OPW-1:0] OP_RTYPE = 6'd0,
  parameter logic [OPW-1:0] OP_JUMP  = 6'd2,
  parameter logic [OPW-1:0] OP_BEQ   = 6'd4,
  parameter logic [OPW-1:0] OP_LOAD  = 6'd35,
  parameter logic [OPW-1:0] OP_STORE = 6'd43
) (
  input  logic [OPW-1:0] opcode,
  input  logic [FNW-1:0] funct,
  output logic           dst_from_rd,
  output logic           b_from_imm,
  output logic           wb_from_mem,
  output logic           rf_we,
  output logic           dm_re,
  output logic           dm_we,
  output logic           is_branch,
  output logic           is_jump,
  output logic [1:0]     alu_class,
  output logic [AW-1:0]  alu_fn
);

  localparam logic [1:0] CL_MEM = 2'b00;
  localparam logic [1:0] CL_BEQ = 2'b01;
  localparam logic [1:0] CL_ARI = 2'b10;
  localparam logic [1:0] CL_JMP = 2'b11;

  localparam logic [AW-1:0] FN_AND = 3'b000;
  localparam logic [AW-1:0] FN_OR  = 3'b001;
  localparam logic [AW-1:0] FN_ADD = 3'b010;
  localparam logic [AW-1:0] FN_SUB = 3'b110;
  localparam logic [AW-1:0] FN_SLT = 3'b111;

  logic       main_we;
  logic       fn_ok;

  always_comb begin
    dst_from_rd = 1'b0;
    b_from_imm  = 1'b0;
    wb_from_mem = 1'b0;
    main_we     = 1'b0;
    dm_re       = 1'b0;
    dm_we       = 1'b0;
    is_branch   = 1'b0;
    is_jump     = 1'b0;
    alu_class   = CL_MEM;
    case (opcode)
      OP_RTYPE: begin
        dst_from_rd = 1'b1;
        main_we     = 1'b1;
        alu_class   = CL_ARI;
      end
      OP_LOAD: begin
        b_from_imm  = 1'b1;
        wb_from_mem = 1'b1;
        main_we     = 1'b1;
        dm_re       = 1'b1;
      end
      OP_STORE: begin
        b_from_imm  = 1'b1;
        dm_we       = 1'b1;
      end
      OP_BEQ: begin
        is_branch   = 1'b1;
        alu_class   = CL_BEQ;
      end
      OP_JUMP: begin
        is_jump     = 1'b1;
        alu_class   = CL_JMP;
      end
      default: ;
    endcase
  end

  always_comb begin
    fn_ok  = 1'b1;
    alu_fn = FN_AND;
    case (alu_class)
      CL_MEM: alu_fn = FN_ADD;
      CL_BEQ: alu_fn = FN_SUB;
      CL_ARI: begin
        case (funct)
          6'd32:   alu_fn = FN_ADD;
          6'd34:   alu_fn = FN_SUB;
          6'd36:   alu_fn = FN_AND;
          6'd37:   alu_fn = FN_OR;
          6'd42:   alu_fn = FN_SLT;
          default: fn_ok  = 1'b0;
        endcase
      end
      default: alu_fn = FN_AND;
    endcase
  end

  assign rf_we = main_we & fn_ok;

endmodule

// File: rtl/ctrl_decoder_chk.sv
module ctrl_decoder_chk (
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic       dst_from_rd,
  input logic       b_from_imm,
  input logic       wb_from_mem,
  input logic       rf_we,
  input logic       dm_re,
  input logic       dm_we,
  input logic       is_branch,
  input logic       is_jump,
  input logic [1:0] alu_class,
  input logic [2:0] alu_fn
);

  logic known_op;
  assign known_op = (opcode == 6'd0) || (opcode == 6'd2) || (opcode == 6'd4) ||
                    (opcode == 6'd35) || (opcode == 6'd43);

  always_comb begin
    if (!$isunknown({opcode, funct})) begin
      AST_LOAD_FIELDS: assert (opcode != 6'd35 || (rf_we && dm_re && wb_from_mem && !dm_we)) else $error("load"); // R1
      AST_RTYPE_CLASS: assert (opcode != 6'd0 || (alu_class == 2'b10 && dst_from_rd && !dm_re && !dm_we)) else $error("rtype"); // R2
      AST_STORE_NOWB: assert (opcode != 6'd43 || (dm_we && !rf_we && !dm_re)) else $error("store"); // R3
      AST_BEQ_SUB: assert (!is_branch || (alu_fn == 3'b110 && !rf_we && !dm_we && !dm_re)) else $error("beq"); // R4
      AST_JUMP_QUIET: assert (!is_jump || (!rf_we && !dm_we && !dm_re && !is_branch)) else $error("jump"); // R5
      AST_UNKNOWN_FUNCT: assert (!(opcode == 6'd0 && alu_fn == 3'b000 && funct != 6'd36) || !rf_we) else $error("funct"); // R7
      AST_UNKNOWN_OP: assert (known_op || !(rf_we || dm_re || dm_we || is_branch || is_jump)) else $error("op"); // R8
      AST_CLASS_FORCE: assert (alu_class != 2'b00 || alu_fn == 3'b010) else $error("class"); // R9
      AST_ONE_MEM_EN: assert (!(dm_re && dm_we)) else $error("mem"); // R3
      AST_FLOW_EXCL: assert ($countones({is_branch, is_jump, dm_we}) <= 1) else $error("flow"); // R5
    end
  end

endmodule

bind ctrl_decoder ctrl_decoder_chk chk_i (.*);

// File: tb/ctrl_decoder_tb_top.sv
`timescale 1ns/1ps
module ctrl_decoder_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [5:0] opcode = 6'd0;
  logic [5:0] funct  = 6'd0;
  logic dst_from_rd, b_from_imm, wb_from_mem, rf_we, dm_re, dm_we, is_branch, is_jump;
  logic [1:0] alu_class;
  logic [2:0] alu_fn;

  ctrl_decoder dut_i (
    .opcode(opcode), .funct(funct),
    .dst_from_rd(dst_from_rd), .b_from_imm(b_from_imm), .wb_from_mem(wb_from_mem),
    .rf_we(rf_we), .dm_re(dm_re), .dm_we(dm_we), .is_branch(is_branch),
    .is_jump(is_jump), .alu_class(alu_class), .alu_fn(alu_fn)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // {opcode, funct, dst,src,wb,we,re,mwe,br,j, class, fn, req}
  localparam int NV = 16;
  localparam logic [28:0] VEC [NV] = '{
    {6'd35, 6'd0,  13'b0_1_1_1_1_0_0_0_00_010, 4'd1},  // R1
    {6'd0,  6'd32, 13'b1_0_0_1_0_0_0_0_10_010, 4'd2},  // R2
    {6'd0,  6'd34, 13'b1_0_0_1_0_0_0_0_10_110, 4'd6},  // R6
    {6'd0,  6'd36, 13'b1_0_0_1_0_0_0_0_10_000, 4'd6},  // R6
    {6'd0,  6'd37, 13'b1_0_0_1_0_0_0_0_10_001, 4'd6},  // R6
    {6'd0,  6'd42, 13'b1_0_0_1_0_0_0_0_10_111, 4'd6},  // R6
    {6'd43, 6'd0,  13'b0_1_0_0_0_1_0_0_00_010, 4'd3},  // R3
    {6'd4,  6'd32, 13'b0_0_0_0_0_0_1_0_01_110, 4'd4},  // R4
    {6'd2,  6'd0,  13'b0_0_0_0_0_0_0_1_11_000, 4'd5},  // R5
    {6'd0,  6'd33, 13'b1_0_0_0_0_0_0_0_10_000, 4'd7},  // R7
    {6'd0,  6'd63, 13'b1_0_0_0_0_0_0_0_10_000, 4'd7},  // R7
    {6'd8,  6'd32, 13'b0_0_0_0_0_0_0_0_00_010, 4'd8},  // R8
    {6'd63, 6'd42, 13'b0_0_0_0_0_0_0_0_00_010, 4'd8},  // R8
    {6'd35, 6'd42, 13'b0_1_1_1_1_0_0_0_00_010, 4'd9},  // R9
    {6'd43, 6'd34, 13'b0_1_0_0_0_1_0_0_00_010, 4'd9},  // R9
    {6'd4,  6'd37, 13'b0_0_0_0_0_0_1_0_01_110, 4'd9}   // R9
  };

  function automatic logic [12:0] got_bits();
    return {dst_from_rd, b_from_imm, wb_from_mem, rf_we, dm_re, dm_we,
            is_branch, is_jump, alu_class, alu_fn};
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn);
    @(posedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
  endtask

  task automatic check(input logic [12:0] exp, input int req);
    total++;
    if (got_bits() !== exp) begin
      bad++;
      $display("FAIL R%0d op=%0d fn=%0d got=%b exp=%b", req, opcode, funct, got_bits(), exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // start-up inputs: opcode 0 funct 0 is R-type with unsupported function (R7)
    check(13'b1_0_0_0_0_0_0_0_10_000, 7);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][28:23], VEC[i][22:17]);
      check(VEC[i][16:4], int'(VEC[i][3:0]));
    end

    // R8 sweep: every unsupported opcode with a valid function code
    for (int op = 0; op < 64; op++) begin
      if (op != 0 && op != 2 && op != 4 && op != 35 && op != 43) begin
        apply(6'(op), 6'd32);
        check(13'b0_0_0_0_0_0_0_0_00_010, 8);
      end
    end

    // R6 / R7 sweep over all function codes under R-type
    for (int f = 0; f < 64; f++) begin
      logic [12:0] e;
      apply(6'd0, 6'(f));
      case (f)
        32: e = 13'b1_0_0_1_0_0_0_0_10_010;
        34: e = 13'b1_0_0_1_0_0_0_0_10_110;
        36: e = 13'b1_0_0_1_0_0_0_0_10_000;
        37: e = 13'b1_0_0_1_0_0_0_0_10_001;
        42: e = 13'b1_0_0_1_0_0_0_0_10_111;
        default: e = 13'b1_0_0_0_0_0_0_0_10_000;
      endcase
      check(e, (f == 32 || f == 34 || f == 36 || f == 37 || f == 42) ? 6 : 7);
    end

    // R9 / R1: load is unaffected by every function code
    for (int f = 0; f < 64; f++) begin
      apply(6'd35, 6'(f));
      check(13'b0_1_1_1_1_0_0_0_00_010, 9);
    end

    // R5: jump with an arithmetic function code still writes nothing
    apply(6'd2, 6'd42);
    check(13'b0_0_0_0_0_0_0_1_11_000, 5);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule